// File: doc/BRIEF.md
# Per-Pin Selectable Input Debouncer

This block cleans up four slow general-purpose input pins before the rest of the chip sees them. Every pin first crosses into the local clock domain through a two-flop synchroniser. After that it either passes straight to its output or goes through a stability filter. The filter accepts a new level only once that level has been held for a full window.

Two byte-wide configuration registers control the pins. The register at address 0 holds a filter-enable bit for each pin. The register at address 1 holds a window-select bit for each pin, which picks a short window of a few microseconds or a long window of tens of milliseconds. Window lengths are counted in ticks of a shared microsecond timebase. The tick divider comes from the clock-frequency parameter, so one set of RTL serves any clock rate.

The pin path has no handshake: pins are level signals and the filtered outputs are plain levels. The configuration port is a single-cycle write strobe plus a combinational read of the addressed register. There is no back-pressure anywhere.

Top module: `gpin_filter`

## Requirements
- R1: Bit i (i = 0..3) of the register at cfg_addr = 0 enables filtering on pin i. It is written with cfg_we and read back on cfg_rdata.
- R2: Bit i of the register at cfg_addr = 1 selects the window of pin i. A value of 0 selects SHORT_US microseconds and a value of 1 selects LONG_US microseconds.
- R3: Bits 7:4 of both registers ignore writes and always read as zero.
- R4: While rst_n is low, both registers read 0x00 and every filtered output is 0.
- R5: A pin with filtering disabled shows a new level on its output at the third rising clock edge after the level is applied, because it passes through two synchroniser flops and the output flop.
- R6: A pin with filtering enabled and a window of W ticks changes its output only after the synchronised input has differed from the output for W consecutive ticks. With one tick per cycle, a held change appears at rising edge W+2 after it is applied.
- R7: On an enabled pin, a pulse away from the current output level that is shorter than W ticks leaves the output unchanged and restarts the count.
- R8: When the enable bit of a pin is clear, its output takes the synchronised input on the next edge and its counter stays at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw asynchronous input pins |
| pin_o | output | NPINS | Synchronised and filtered pin levels |
| cfg_we | input | 1 | Write strobe for the addressed register |
| cfg_addr | input | 1 | Register select: 0 = filter enable, 1 = window select |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the addressed register, upper bits zero |

## Verification
The bench builds the block with CLK_KHZ = 1000, SHORT_US = 4 and LONG_US = 12. This makes the timebase tick on every clock, so each window is an exact number of cycles. It also brings the full 25 ms window down to twelve cycles, which lets the bench place pulses one cycle shorter than, or exactly as long as, either window. The table sets up two unfiltered pins, one short-window pin and one long-window pin side by side, so each input pattern checks passthrough latency, both window lengths and the restart of the count at the same time.

// File: rtl/gpf_pkg.sv
package gpf_pkg;

  typedef enum logic {
    GPF_REG_ENABLE = 1'b0,
    GPF_REG_WINDOW = 1'b1
  } gpf_reg_e;

  localparam int GPF_REG_BITS = 8;

  function automatic int gpf_tick_div(input int clk_khz);
    int d;
    d = clk_khz / 1000;
    return (d < 1) ? 1 : d;
  endfunction

endpackage

// File: rtl/gpf_regs.sv
module gpf_regs
  import gpf_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  output logic [NPINS-1:0] en_o,
  output logic [NPINS-1:0] sel_o
);

  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= '0;
    end else if (cfg_we) begin
      if (gpf_reg_e'(cfg_addr) == GPF_REG_ENABLE) en_q <= cfg_wdata[NPINS-1:0];
      else sel_q <= cfg_wdata[NPINS-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (gpf_reg_e'(cfg_addr) == GPF_REG_ENABLE) cfg_rdata[NPINS-1:0] = en_q;
    else cfg_rdata[NPINS-1:0] = sel_q;
  end

  assign en_o  = en_q;
  assign sel_o = sel_q;

endmodule

// File: rtl/gpf_timebase.sv
module gpf_timebase #(
  parameter int TICK_DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  generate
    if (TICK_DIV <= 1) begin : g_every_cycle
      assign tick_o = 1'b1;
    end else begin : g_divider
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/gpf_sync2.sv
module gpf_sync2 #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] d_i,
  output logic [NPINS-1:0] q_o
);

  logic [NPINS-1:0] meta_q;
  logic [NPINS-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/gpf_pin_filter.sv
module gpf_pin_filter #(
  parameter int CW          = 15,
  parameter int SHORT_TICKS = 7,
  parameter int LONG_TICKS  = 25000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          sel_i,
  input  logic          sync_i,
  output logic          out_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_TICKS - 1);
  localparam logic [CW-1:0] LONG_M1  = CW'(LONG_TICKS - 1);

  logic          out_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit = sel_i ? LONG_M1 : SHORT_M1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en_i) begin
      out_q <= sync_i;
      cnt_q <= '0;
    end else if (sync_i == out_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q >= limit) begin
        out_q <= sync_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign out_o = out_q;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/gpin_filter.sv
module gpin_filter
  import gpf_pkg::*;
#(
  parameter int NPINS    = 4,
  parameter int CLK_KHZ  = 50000,
  parameter int SHORT_US = 7,
  parameter int LONG_US  = 25000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata
);

  localparam int TICK_DIV = gpf_tick_div(CLK_KHZ);
  localparam int MAX_US   = (LONG_US > SHORT_US) ? LONG_US : SHORT_US;
  localparam int CW       = $clog2(MAX_US + 1);

  logic [NPINS-1:0]    en_bits;
  logic [NPINS-1:0]    sel_bits;
  logic [NPINS-1:0]    pin_sync;
  logic [NPINS*CW-1:0] cnt_flat;
  logic                tick;

  gpf_regs #(.NPINS(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .en_o      (en_bits),
    .sel_o     (sel_bits)
  );

  gpf_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  gpf_sync2 #(.NPINS(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpf_pin_filter #(
      .CW          (CW),
      .SHORT_TICKS (SHORT_US),
      .LONG_TICKS  (LONG_US)
    ) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .en_i   (en_bits[i]),
      .sel_i  (sel_bits[i]),
      .sync_i (pin_sync[i]),
      .out_o  (pin_o[i]),
      .cnt_o  (cnt_flat[i*CW +: CW])
    );
  end

endmodule

// File: rtl/gpf_checker.sv
module gpf_checker #(
  parameter int NPINS  = 4,
  parameter int CW     = 15,
  parameter int MAX_US = 25000
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NPINS-1:0]    en_q,
  input logic [NPINS-1:0]    sel_q,
  input logic [NPINS-1:0]    sync_q,
  input logic [NPINS-1:0]    out_q,
  input logic [NPINS*CW-1:0] cnt_flat,
  input logic [7:0]          rdata
);

  localparam logic [CW-1:0] MAX_M1 = CW'(MAX_US - 1);

  AST_RESET_REGS_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (en_q == '0 && sel_q == '0) || !rst_n); // R4

  if (NPINS < 8) begin : g_rsvd
    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[7:NPINS] == '0); // R3
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    logic [CW-1:0] cnt_i;
    assign cnt_i = cnt_flat[i*CW +: CW];

    AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[i] |=> out_q[i] == $past(sync_q[i])); // R8

    AST_CNT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[i] |=> cnt_i == '0); // R8

    AST_NO_FLIP_WHEN_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && sync_q[i] == out_q[i]) |=> ($stable(out_q[i]) && cnt_i == '0)); // R7

    AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_i <= MAX_M1); // R6
  end

endmodule

bind gpin_filter gpf_checker #(
  .NPINS  (NPINS),
  .CW     (CW),
  .MAX_US (MAX_US)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_q     (en_bits),
  .sel_q    (sel_bits),
  .sync_q   (pin_sync),
  .out_q    (pin_o),
  .cnt_flat (cnt_flat),
  .rdata    (cfg_rdata)
);

// File: tb/gpin_filter_bench.sv
module gpin_filter_bench;

  localparam int NPINS = 4;
  localparam int NVEC  = 9;

  // pins 0 and 3 unfiltered, pin 1 short window (4), pin 2 long window (12)
  localparam logic [3:0] VEC_PIN [NVEC] = '{4'hF, 4'hF, 4'hF, 4'h0, 4'hF, 4'h0, 4'h0, 4'hF, 4'h0};
  localparam int         VEC_HOLD[NVEC] = '{3, 3, 8, 3, 20, 6, 8, 11, 20};
  localparam logic [3:0] VEC_EXP [NVEC] = '{4'b1001, 4'b1011, 4'b1111, 4'b0110, 4'b1111,
                                             4'b0100, 4'b0000, 4'b1011, 4'b0000};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pin_i = '0;
  logic [NPINS-1:0] pin_o;
  logic             cfg_we = 1'b0;
  logic             cfg_addr = 1'b0;
  logic [7:0]       cfg_wdata = '0;
  logic [7:0]       cfg_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpin_filter #(
    .NPINS    (NPINS),
    .CLK_KHZ  (1000),
    .SHORT_US (4),
    .LONG_US  (12)
  ) u_gpin_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin_i),
    .pin_o     (pin_o),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic cfg_write(input logic addr, input logic [7:0] data);
    cfg_addr  = addr;
    cfg_wdata = data;
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic cfg_read(input logic addr, output logic [7:0] data);
    cfg_addr = addr;
    #1 data = cfg_rdata;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    wait_neg(3);
    // R4: reset state
    check({4'h0, pin_o}, 8'h00, "R4 outputs in reset");
    cfg_read(1'b0, rd);
    check(rd, 8'h00, "R4 enable register in reset");
    cfg_read(1'b1, rd);
    check(rd, 8'h00, "R4 window register in reset");
    rst_n = 1'b1;
    wait_neg(2);

    // R1 / R2: configure and read back
    cfg_write(1'b0, 8'h06);
    cfg_write(1'b1, 8'h04);
    cfg_read(1'b0, rd);
    check(rd, 8'h06, "R1 enable readback");
    cfg_read(1'b1, rd);
    check(rd, 8'h04, "R2 window readback");
    wait_neg(4);

    // table walk: R5 passthrough, R6 windows, R7 short pulses restart
    for (int v = 0; v < NVEC; v++) begin
      pin_i = VEC_PIN[v];
      wait_neg(VEC_HOLD[v]);
      check({4'h0, pin_o}, {4'h0, VEC_EXP[v]}, $sformatf("R5/R6/R7 vector %0d", v));
    end

    // R3: upper nibble ignored on both registers
    cfg_write(1'b0, 8'hF6);
    cfg_read(1'b0, rd);
    check(rd, 8'h06, "R3 enable upper nibble");
    cfg_write(1'b1, 8'hA4);
    cfg_read(1'b1, rd);
    check(rd, 8'h04, "R3 window upper nibble");

    // R8: disabling a pin mid-window makes it follow at once
    pin_i = 4'h4;
    wait_neg(4);
    check({7'h0, pin_o[2]}, 8'h00, "R6 long pin still held");
    cfg_write(1'b0, 8'h02);
    wait_neg(1);
    check({7'h0, pin_o[2]}, 8'h01, "R8 disabled pin follows next edge");

    // R2: per-pin select change, pin 3 on long window
    cfg_write(1'b1, 8'h08);
    cfg_write(1'b0, 8'h08);
    wait_neg(2);
    pin_i = 4'hC;
    wait_neg(13);
    check({7'h0, pin_o[3]}, 8'h00, "R2 long window not yet elapsed");
    wait_neg(1);
    check({7'h0, pin_o[3]}, 8'h01, "R2 R6 long window elapsed");

    // R4: reset mid-run clears registers and outputs
    rst_n = 1'b0;
    #1;
    check({4'h0, pin_o}, 8'h00, "R4 outputs cleared by reset");
    cfg_read(1'b0, rd);
    check(rd, 8'h00, "R4 enable cleared by reset");
    wait_neg(2);
    rst_n = 1'b1;
    wait_neg(2);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule